// File: doc/BRIEF.md
# Debug Bus Comparator Channel

This block is one channel of an on-chip debug comparator. On every cycle it looks at the CPU bus: address, data, direction and an opcode-fetch qualifier. It compares what it sees with a programmed address and data word. A set of control bits decides how a hit is reported.

In immediate mode, a qualifying bus cycle raises a request to the debug state sequencer on the next cycle. In tag mode, a hit on an opcode fetch only marks that opcode in a small fetch/execute queue. The request is raised when that opcode retires through the execute handshake. A pipeline flush discards every pending mark. A break control bit turns any reported hit into a session-termination request, which also disarms the channel. That termination carries a breakpoint request when the global breakpoint enable is high.

The data comparison is present only when the `HAS_DATA` parameter is set. The channel with that parameter set plays the role of the data-capable comparator. Other channels match on address and qualifiers alone.

Top module: `dbg_cmp_channel`

## Requirements
- R1: While `cfg_en` is 0, the channel raises no `seq_req`, `term_req` or `bkpt_req`, and marks no opcode.
- R2: With `cfg_tag`=0, a qualifying bus cycle (`bus_valid`=1 and `bus_addr`=`cmp_addr`) raises a one-cycle pulse on `seq_req` in the cycle after it. An address miss raises nothing.
- R3: With `cfg_rwe`=0, the value of `bus_rd` does not affect a match. With `cfg_rwe`=1, `cfg_rw`=1 matches only read cycles (`bus_rd`=1) and `cfg_rw`=0 matches only write cycles (`bus_rd`=0).
- R4: With `HAS_DATA`=1 and `cfg_ndb`=0, a match needs `bus_data`=`cmp_data`. With `cfg_ndb`=1, a match needs `bus_data`≠`cmp_data`.
- R5: With `cfg_tag`=1, a fetch (`bus_valid`=1, `bus_opfetch`=1) at `cmp_addr` marks that opcode and raises nothing by itself. The request pulses in the cycle after the `exec_ack` that retires the marked opcode. In this mode `cfg_rwe`, `cfg_rw`, `cfg_ndb` and the data bus are ignored.
- R6: With `cfg_brk`=1, a reported hit pulses `term_req` instead of `seq_req`. It clears `armed` and erases all pending marks.
- R7: `bkpt_req` pulses together with `term_req` only when `brk_en` was 1 in the cycle of the hit.
- R8: After reset `armed` is 0. While `armed` is 0 nothing is reported or marked. A one-cycle `arm` pulse sets `armed` to 1 from the next cycle, and `arm` takes priority over a same-cycle disarm.
- R9: `flush` empties the tag queue in the same cycle. A marked opcode that is flushed never fires, even when `exec_ack` comes in the same cycle.
- R10: The tag queue holds 3 opcodes, oldest first. A fetch into a full queue without a same-cycle retire is dropped. An `exec_ack` with an empty queue has no effect. A same-cycle fetch and retire both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Channel enable |
| cfg_tag | input | 1 | 1 = tag opcode fetches, 0 = report immediately |
| cfg_brk | input | 1 | 1 = hit terminates the session |
| cfg_rw | input | 1 | Direction to match: 1 read, 0 write |
| cfg_rwe | input | 1 | 1 = direction takes part in the comparison |
| cfg_ndb | input | 1 | 1 = match on data inequality |
| cmp_addr | input | ADDR_W | Programmed address |
| cmp_data | input | DATA_W | Programmed data word |
| arm | input | 1 | One-cycle arm pulse |
| brk_en | input | 1 | Global breakpoint enable |
| bus_valid | input | 1 | Bus cycle present |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | DATA_W | Bus data |
| bus_rd | input | 1 | 1 read, 0 write |
| bus_opfetch | input | 1 | Cycle is an opcode fetch |
| exec_ack | input | 1 | Oldest fetched opcode reaches execute |
| flush | input | 1 | Pipeline flush |
| seq_req | output | 1 | Sequencer transition request pulse |
| term_req | output | 1 | Session termination request pulse |
| bkpt_req | output | 1 | Breakpoint request pulse |
| armed | output | 1 | Channel is armed |

## Verification
The embedded properties check these on every cycle:
- the sequencer and termination requests never overlap;
- a breakpoint never appears without a termination;
- a termination leaves the channel disarmed unless it was re-armed in the same cycle;
- a disabled or disarmed channel stays silent;
- the tag queue stays contiguous and is empty after a flush.

Other behaviour only the bench scenarios can show, because it depends on a sequence of events:
- a marked opcode must fire exactly when it retires, and not when other opcodes retire;
- marks must survive queue shifting;
- a full queue must drop a fetch;
- the direction and data qualifiers must decide a hit in immediate mode but not in tag mode.

// File: rtl/dbg_cmp_pkg.sv
package dbg_cmp_pkg;

    typedef struct packed {
        logic en;
        logic tag;
        logic brk;
        logic rw;
        logic rwe;
        logic ndb;
    } cmp_ctrl_t;

    typedef struct packed {
        logic armed;
        logic seq;
        logic term;
        logic bkpt;
    } chan_state_t;

endpackage

// File: rtl/dbg_cmp_match.sv
module dbg_cmp_match
    import dbg_cmp_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter bit HAS_DATA = 1'b1
) (
    input  cmp_ctrl_t          ctrl,
    input  logic [ADDR_W-1:0]  cmp_addr,
    input  logic [DATA_W-1:0]  cmp_data,
    input  logic               bus_valid,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_data,
    input  logic               bus_rd,
    input  logic               bus_opfetch,
    output logic               imm_hit,
    output logic               tag_mark
);

    logic addr_eq;
    logic dir_ok;
    logic data_ok;

    assign addr_eq = bus_valid && (bus_addr == cmp_addr);

    always_comb begin
        if (!ctrl.rwe) begin
            dir_ok = 1'b1;
        end else if (ctrl.rw) begin
            dir_ok = bus_rd;
        end else begin
            dir_ok = !bus_rd;
        end
    end

    generate
        if (HAS_DATA) begin : g_data
            logic data_eq;
            assign data_eq = (bus_data == cmp_data);
            assign data_ok = ctrl.ndb ? !data_eq : data_eq;
        end else begin : g_nodata
            logic unused_data;
            assign unused_data = ^{bus_data, cmp_data, ctrl.ndb};
            assign data_ok = 1'b1;
        end
    endgenerate

    // Immediate-mode hit uses every qualifier. A tag mark looks only at the fetch address.
    assign imm_hit  = addr_eq && dir_ok && data_ok;
    assign tag_mark = addr_eq && bus_opfetch;

endmodule

// File: rtl/dbg_cmp_tagq.sv
module dbg_cmp_tagq #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic fetch,
    input  logic fetch_tag,
    input  logic exec_ack,
    input  logic clear_tags,
    output logic pop_tag
);

    typedef struct packed {
        logic [DEPTH-1:0] vld;
        logic [DEPTH-1:0] tag;
    } q_t;

    q_t q_d, q_q;

    always_comb begin
        int cnt;
        logic pop;
        q_d     = q_q;
        pop     = exec_ack && q_q.vld[0];
        pop_tag = pop && q_q.tag[0] && !flush;

        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                q_d.vld[i] = q_q.vld[i+1];
                q_d.tag[i] = q_q.tag[i+1];
            end
            q_d.vld[DEPTH-1] = 1'b0;
            q_d.tag[DEPTH-1] = 1'b0;
        end

        cnt = 0;
        for (int i = 0; i < DEPTH; i++) begin
            cnt += int'(q_d.vld[i]);
        end

        if (fetch && cnt < DEPTH) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i == cnt) begin
                    q_d.vld[i] = 1'b1;
                    q_d.tag[i] = fetch_tag;
                end
            end
        end

        if (clear_tags) begin
            q_d.tag = '0;
        end

        if (flush) begin
            q_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    AST_VLD_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        ((q_q.vld + 1'b1) & q_q.vld) == '0); // R10

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q_q.vld == '0)); // R9

    AST_NO_TAG_WITHOUT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.tag & ~q_q.vld) == '0); // R10

endmodule

// File: rtl/dbg_cmp_channel.sv
module dbg_cmp_channel
    import dbg_cmp_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter bit HAS_DATA = 1'b1,
    parameter int TAGQ_DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_tag,
    input  logic              cfg_brk,
    input  logic              cfg_rw,
    input  logic              cfg_rwe,
    input  logic              cfg_ndb,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [DATA_W-1:0] cmp_data,
    input  logic              arm,
    input  logic              brk_en,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_rd,
    input  logic              bus_opfetch,
    input  logic              exec_ack,
    input  logic              flush,
    output logic              seq_req,
    output logic              term_req,
    output logic              bkpt_req,
    output logic              armed
);

    cmp_ctrl_t   ctrl;
    chan_state_t st_d, st_q;
    logic        imm_hit;
    logic        tag_mark;
    logic        pop_tag;
    logic        live;
    logic        hit_evt;
    logic        kill;

    assign ctrl = '{en: cfg_en, tag: cfg_tag, brk: cfg_brk,
                    rw: cfg_rw, rwe: cfg_rwe, ndb: cfg_ndb};

    dbg_cmp_match #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .HAS_DATA (HAS_DATA)
    ) u_match (
        .ctrl        (ctrl),
        .cmp_addr    (cmp_addr),
        .cmp_data    (cmp_data),
        .bus_valid   (bus_valid),
        .bus_addr    (bus_addr),
        .bus_data    (bus_data),
        .bus_rd      (bus_rd),
        .bus_opfetch (bus_opfetch),
        .imm_hit     (imm_hit),
        .tag_mark    (tag_mark)
    );

    dbg_cmp_tagq #(
        .DEPTH (TAGQ_DEPTH)
    ) u_tagq (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .fetch      (bus_valid && bus_opfetch),
        .fetch_tag  (live && ctrl.tag && tag_mark),
        .exec_ack   (exec_ack),
        .clear_tags (kill),
        .pop_tag    (pop_tag)
    );

    assign live    = ctrl.en && st_q.armed;
    assign hit_evt = live && (ctrl.tag ? pop_tag : imm_hit);
    assign kill    = hit_evt && ctrl.brk;

    always_comb begin
        st_d      = st_q;
        st_d.seq  = hit_evt && !ctrl.brk;
        st_d.term = kill;
        st_d.bkpt = kill && brk_en;
        if (arm) begin
            st_d.armed = 1'b1;
        end else if (kill) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seq_req  = st_q.seq;
    assign term_req = st_q.term;
    assign bkpt_req = st_q.bkpt;
    assign armed    = st_q.armed;

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_req && term_req)); // R6

    AST_BKPT_WITH_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_req |-> term_req); // R7

    AST_TERM_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (term_req && !$past(arm)) |-> !armed); // R6

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!seq_req && !term_req)); // R1

    AST_DISARMED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (!seq_req && !term_req && !bkpt_req)); // R8

    AST_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> armed); // R8

endmodule

// File: tb/sim_dbg_cmp_channel.sv
`timescale 1ns/1ps
module sim_dbg_cmp_channel;

    localparam int AW = 16;
    localparam int DW = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n;
    logic c_en, c_tag, c_brk, c_rw, c_rwe, c_ndb;
    logic [AW-1:0] cmp_addr;
    logic [DW-1:0] cmp_data;
    logic arm, brk_en;
    logic bus_valid, bus_rd, bus_opfetch, exec_ack, flush;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;
    logic seq_req, term_req, bkpt_req, armed;

    dbg_cmp_channel u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(c_en), .cfg_tag(c_tag), .cfg_brk(c_brk),
        .cfg_rw(c_rw), .cfg_rwe(c_rwe), .cfg_ndb(c_ndb),
        .cmp_addr(cmp_addr), .cmp_data(cmp_data),
        .arm(arm), .brk_en(brk_en),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_rd(bus_rd), .bus_opfetch(bus_opfetch),
        .exec_ack(exec_ack), .flush(flush),
        .seq_req(seq_req), .term_req(term_req),
        .bkpt_req(bkpt_req), .armed(armed)
    );

    int    checks = 0;
    int    errors = 0;
    string req = "R8";
    bit    done = 0;

    // reference model state
    bit m_armed;
    bit mq[$];
    bit e_seq, e_term, e_bkpt;

    task automatic check(string r, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", r, what, act, exp);
        end
    endtask

    task automatic model_step();
        bit fire, hit, mark, ev, rwok, dok, fetch;
        if (!rst_n) begin
            m_armed = 0; mq.delete();
            e_seq = 0; e_term = 0; e_bkpt = 0;
            return;
        end
        fire  = !flush && exec_ack && mq.size() > 0 && mq[0];
        rwok  = !c_rwe || (c_rw ? bus_rd : !bus_rd);
        dok   = c_ndb ? (bus_data != cmp_data) : (bus_data == cmp_data);
        hit   = bus_valid && bus_addr == cmp_addr && rwok && dok;
        ev    = c_en && m_armed && (c_tag ? fire : hit);
        fetch = bus_valid && bus_opfetch;
        mark  = c_en && m_armed && c_tag && fetch && bus_addr == cmp_addr;
        if (flush) begin
            mq.delete();
        end else begin
            if (exec_ack && mq.size() > 0) void'(mq.pop_front());
            if (fetch && mq.size() < 3) mq.push_back(mark);
        end
        if (ev && c_brk) foreach (mq[i]) mq[i] = 0;
        e_seq  = ev && !c_brk;
        e_term = ev && c_brk;
        e_bkpt = ev && c_brk && brk_en;
        if (arm) m_armed = 1;
        else if (ev && c_brk) m_armed = 0;
    endtask

    task automatic idle();
        bus_valid = 0; bus_opfetch = 0; bus_rd = 0;
        bus_addr = '0; bus_data = '0;
        exec_ack = 0; flush = 0; arm = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(req, "seq_req",  seq_req,  e_seq);
        check(req, "term_req", term_req, e_term);
        check(req, "bkpt_req", bkpt_req, e_bkpt);
        check(req, "armed",    armed,    m_armed);
        idle();
    endtask

    task automatic bus(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic rd, input logic opf, input logic ex);
        bus_valid = 1; bus_addr = a; bus_data = d;
        bus_rd = rd; bus_opfetch = opf; exec_ack = ex;
        tick();
    endtask

    task automatic cfg(input logic en, input logic tg, input logic bk,
                       input logic rw, input logic rwe, input logic ndb);
        c_en = en; c_tag = tg; c_brk = bk; c_rw = rw; c_rwe = rwe; c_ndb = ndb;
    endtask

    task automatic do_arm();
        arm = 1; tick();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    localparam logic [AW-1:0] A  = 16'h4A10;
    localparam logic [DW-1:0] D  = 16'h00FF;

    initial begin
        cmp_addr = A; cmp_data = D; brk_en = 0;
        cfg(1, 0, 0, 0, 0, 0);
        idle();
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        req = "R8"; tick();
        check("R8", "armed after reset", armed, 1'b0);
        bus(A, D, 0, 0, 0);               // disarmed: silent
        tick();
        do_arm(); tick();

        req = "R2";
        bus(A, D, 1, 0, 0); tick();       // hit
        bus(A ^ 16'h1, D, 1, 0, 0); tick(); // miss
        bus(A, D, 0, 0, 0); bus(A, D, 1, 0, 0); tick(); // back-to-back

        req = "R3";
        cfg(1, 0, 0, 1, 1, 0);
        bus(A, D, 1, 0, 0); tick();       // read matches
        bus(A, D, 0, 0, 0); tick();       // write rejected
        cfg(1, 0, 0, 0, 1, 0);
        bus(A, D, 0, 0, 0); tick();       // write matches
        bus(A, D, 1, 0, 0); tick();       // read rejected

        req = "R4";
        cfg(1, 0, 0, 0, 0, 0);
        bus(A, D ^ 16'h10, 0, 0, 0); tick();
        cfg(1, 0, 0, 0, 0, 1);
        bus(A, D ^ 16'h10, 0, 0, 0); tick();
        bus(A, D, 0, 0, 0); tick();

        req = "R1";
        cfg(0, 0, 0, 0, 0, 0);
        bus(A, D, 0, 0, 0); tick();
        cfg(0, 1, 0, 0, 0, 0);
        bus(A, D, 0, 1, 0); bus(16'h0, D, 0, 0, 1); tick();

        req = "R5";
        cfg(1, 1, 0, 1, 1, 1);            // rw/ndb/data must be ignored
        bus(16'h0100, 16'h0, 0, 1, 0);
        bus(A, D, 0, 1, 0);               // marked (write, equal data)
        bus(A, D, 1, 0, 0);               // data access: no mark, no fire
        exec_ack = 1; tick();
        exec_ack = 1; tick();             // marked retires here
        exec_ack = 1; tick();             // empty queue
        bus(A, 16'h1234, 1, 1, 1); exec_ack = 1; tick();

        req = "R10";
        bus(16'h1, 0, 0, 1, 0); bus(16'h2, 0, 0, 1, 0); bus(16'h3, 0, 0, 1, 0);
        bus(A, 0, 0, 1, 0);               // full: dropped
        repeat (3) begin exec_ack = 1; tick(); end
        bus(16'h1, 0, 0, 1, 0); bus(16'h2, 0, 0, 1, 0);
        bus(A, 0, 0, 1, 1);               // fetch + retire together
        repeat (3) begin exec_ack = 1; tick(); end

        req = "R9";
        bus(A, 0, 0, 1, 0); flush = 1; tick();
        exec_ack = 1; tick();
        bus(A, 0, 0, 1, 0); flush = 1; exec_ack = 1; tick();
        exec_ack = 1; tick();

        req = "R6";
        cfg(1, 0, 1, 0, 0, 0); brk_en = 0;
        bus(A, D, 0, 0, 0); tick();
        bus(A, D, 0, 0, 0); tick();       // disarmed now
        req = "R7";
        do_arm(); brk_en = 1;
        bus(A, D, 0, 0, 0); tick();
        do_arm();
        arm = 1; bus(A, D, 0, 0, 0);      // arm wins over disarm
        tick();
        req = "R6";
        cfg(1, 1, 1, 0, 0, 0); do_arm();
        bus(A, 0, 0, 1, 0); bus(A, 0, 0, 1, 0);
        exec_ack = 1; tick();             // first mark: terminate, erase second
        do_arm();
        exec_ack = 1; tick(); tick();

        req = "R2";
        brk_en = 0;
        for (int n = 0; n < 4000; n++) begin
            if (n % 60 == 0)
                cfg($urandom % 8 != 0, $urandom % 2, $urandom % 4 == 0,
                    $urandom % 2, $urandom % 2, $urandom % 2);
            brk_en      = $urandom % 2;
            bus_valid   = $urandom % 4 != 0;
            bus_addr    = ($urandom % 2) ? A : (A ^ 16'h0004);
            bus_data    = ($urandom % 2) ? D : (D ^ 16'h0100);
            bus_rd      = $urandom % 2;
            bus_opfetch = $urandom % 2;
            exec_ack    = $urandom % 2;
            flush       = $urandom % 40 == 0;
            arm         = $urandom % 25 == 0;
            tick();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule